// File: doc/BRIEF.md
# Configurable Logic Cell Core

This block is a single programmable logic element. Four gate signals enter the cell, and one result bit leaves it. A control byte chooses how the gates are combined. There are three purely combinational functions and five functions that keep one bit of state: a set/reset latch, three flip-flop flavours and a transparent latch. The same control byte also enables the cell, enables the pin driver and arms edge interrupts. A separate polarity bit can invert the result.

A software agent configures the cell through a byte-wide write/read bus. It reads back the control byte, which includes a live copy of the result bit, the polarity bit and a sticky interrupt flag. The flag is set by a rising edge, a falling edge or both of the result, as armed in the control byte. It stays set until software writes a 0 to it.

All storage is clocked by the system clock. The clock and enable roles of gate 1 in the flip-flop and latch modes are sampled on that clock.

Top module: `logic_cell_core`

## Requirements
- R1: After reset the control byte, the polarity bit and the interrupt flag are all 0, so the cell starts disabled in mode 000 with both edge interrupts off.
- R2: While the enable bit (control bit 7) is 0, `cell_out` is 0 and the stored state bit is cleared.
- R3: `pin_out` equals `cell_out` when output enable (control bit 6) is 1 and is 0 otherwise. Output enable has no effect on `cell_out`.
- R4: With g1..g4 = `gate_in[0..3]`, the combinational modes give: mode 000 (g1&g2)|(g3&g4), mode 001 (g1|g2)^(g3|g4), mode 010 g1&g2&g3&g4. Each follows the gates in the same cycle.
- R5: Mode 011 is a set/reset latch with set = g1|g2 and reset = g3|g4. Reset wins over set. The stored bit changes at the next clock edge.
- R6: Mode 100 is a D flip-flop: on a clock where g1 is 1 and was 0 at the previous clock, it loads g2. g3 clears the stored bit and g4 sets it. g3 wins over g4, and both win over the clock.
- R7: Mode 101 loads g2^g4 on a g1 rise as in R6, and g3 clears it with priority.
- R8: Mode 110 is a JK flip-flop with J = g2 and K = g4, acting on a g1 rise: 00 holds, 01 clears, 10 sets, 11 toggles. g3 clears it with priority.
- R9: Mode 111 is a latch: g3 clears, else g4 sets, else while g1 is 1 it loads g2. Otherwise it holds.
- R10: When enabled, the polarity bit (bit 0 at address 1) inverts the result seen at `cell_out`, at the status bit and by the edge detector.
- R11: Address 0 reads the control byte with bit 5 replaced by the current `cell_out`; writes to bit 5 are ignored. Bits 4 and 3 are the rising and falling interrupt enables and bits 2:0 the mode. Address 1 bit 0 reads the polarity bit, address 2 bit 0 reads the flag, and every other bit or address reads 0.
- R12: If `cell_out` differs between two consecutive clock samples, the flag is 1 from the second of those edges onward when the matching enable (bit 4 for 0→1, bit 3 for 1→0) was 1 at that edge.
- R13: The flag is cleared only by a write to address 2 with bit 0 = 0. A write with bit 0 = 1 has no effect, and a new edge in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| gate_in | input | 4 | Gate signals g1..g4 on bits 0..3 |
| cell_out | output | 1 | Internal cell result after polarity |
| pin_out | output | 1 | Result gated by output enable |
| irq_flag | output | 1 | Sticky edge interrupt flag |

## Verification
A wrong stored bit in a sequential mode appears on `cell_out` in the cycle after the clock edge that should have set it, and it persists until a reset or load corrects it. The bench therefore compares `cell_out` in every cycle. A missed or spurious edge shows up on `irq_flag` one edge after the output change and then stays visible because the flag is sticky. A lost g1 history shows up as a load one cycle early or a load that never happens. Random gate and register traffic, checked cycle by cycle against a bench model, exposes each of these within a few cycles of the faulty transition.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    localparam int GATE_W = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MODE_AND_OR   = 3'b000,
        MODE_OR_XOR   = 3'b001,
        MODE_AND4     = 3'b010,
        MODE_SR       = 3'b011,
        MODE_DFF_SR   = 3'b100,
        MODE_DFF2_R   = 3'b101,
        MODE_JK_R     = 3'b110,
        MODE_LATCH_SR = 3'b111
    } cell_mode_e;

    typedef struct packed {
        logic       en;
        logic       oe;
        logic       status;
        logic       int_rise;
        logic       int_fall;
        cell_mode_e mode;
    } ctrl_t;

endpackage

// File: rtl/lcc_ctrl_regs.sv
module lcc_ctrl_regs
    import lcc_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int CTRL_ADDR  = 0,
    parameter int POLAR_ADDR = 1,
    parameter int FLAG_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              cell_out,
    input  logic              irq_flag,
    output ctrl_t             ctrl,
    output logic              polarity,
    output logic              flag_clr,
    output logic [BYTE_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(POLAR_ADDR);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);

    typedef struct packed {
        ctrl_t ctrl;
        logic  pol;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        flag_clr = 1'b0;
        if (bus_we) begin
            if (bus_addr == A_CTRL) begin
                regs_d.ctrl        = ctrl_t'(bus_wdata);
                regs_d.ctrl.status = 1'b0;
            end
            if (bus_addr == A_POL) begin
                regs_d.pol = bus_wdata[0];
            end
            if (bus_addr == A_FLAG) begin
                flag_clr = ~bus_wdata[0];
            end
        end

        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata    = BYTE_W'(regs_q.ctrl);
            bus_rdata[5] = cell_out;
        end else if (bus_addr == A_POL) begin
            bus_rdata[0] = regs_q.pol;
        end else if (bus_addr == A_FLAG) begin
            bus_rdata[0] = irq_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl     = regs_q.ctrl;
    assign polarity = regs_q.pol;

endmodule

// File: rtl/lcc_func.sv
module lcc_func
    import lcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  cell_mode_e        mode,
    input  logic              polarity,
    input  logic [GATE_W-1:0] gate_in,
    output logic              cell_out
);

    typedef struct packed {
        logic q;
        logic g1_prev;
    } func_t;

    func_t st_d, st_q;

    logic g1, g2, g3, g4;
    logic g1_rise;
    logic raw;

    assign g1 = gate_in[0];
    assign g2 = gate_in[1];
    assign g3 = gate_in[2];
    assign g4 = gate_in[3];

    always_comb begin
        st_d         = st_q;
        st_d.g1_prev = g1;
        g1_rise      = g1 & ~st_q.g1_prev;
        raw          = st_q.q;

        case (mode)
            MODE_AND_OR: begin
                raw    = (g1 & g2) | (g3 & g4);
                st_d.q = 1'b0;
            end
            MODE_OR_XOR: begin
                raw    = (g1 | g2) ^ (g3 | g4);
                st_d.q = 1'b0;
            end
            MODE_AND4: begin
                raw    = g1 & g2 & g3 & g4;
                st_d.q = 1'b0;
            end
            MODE_SR: begin
                if (g3 | g4)      st_d.q = 1'b0;
                else if (g1 | g2) st_d.q = 1'b1;
            end
            MODE_DFF_SR: begin
                if (g3)           st_d.q = 1'b0;
                else if (g4)      st_d.q = 1'b1;
                else if (g1_rise) st_d.q = g2;
            end
            MODE_DFF2_R: begin
                if (g3)           st_d.q = 1'b0;
                else if (g1_rise) st_d.q = g2 ^ g4;
            end
            MODE_JK_R: begin
                if (g3) begin
                    st_d.q = 1'b0;
                end else if (g1_rise) begin
                    case ({g2, g4})
                        2'b01:   st_d.q = 1'b0;
                        2'b10:   st_d.q = 1'b1;
                        2'b11:   st_d.q = ~st_q.q;
                        default: st_d.q = st_q.q;
                    endcase
                end
            end
            MODE_LATCH_SR: begin
                if (g3)      st_d.q = 1'b0;
                else if (g4) st_d.q = 1'b1;
                else if (g1) st_d.q = g2;
            end
            default: st_d.q = 1'b0;
        endcase

        if (!enable) begin
            st_d.q = 1'b0;
        end

        cell_out = enable & (raw ^ polarity);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lcc_edge_irq.sv
module lcc_edge_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_out,
    input  logic int_rise,
    input  logic int_fall,
    input  logic flag_clr,
    output logic irq_flag
);

    typedef struct packed {
        logic out_prev;
        logic flag;
    } edge_t;

    edge_t ed_d, ed_q;
    logic  rise_ev, fall_ev;

    always_comb begin
        rise_ev       = cell_out & ~ed_q.out_prev;
        fall_ev       = ~cell_out & ed_q.out_prev;
        ed_d.out_prev = cell_out;
        ed_d.flag     = (ed_q.flag & ~flag_clr)
                      | (rise_ev & int_rise)
                      | (fall_ev & int_fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ed_q <= '0;
        end else begin
            ed_q <= ed_d;
        end
    end

    assign irq_flag = ed_q.flag;

endmodule

// File: rtl/logic_cell_core.sv
module logic_cell_core
    import lcc_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int CTRL_ADDR  = 0,
    parameter int POLAR_ADDR = 1,
    parameter int FLAG_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [3:0]        gate_in,
    output logic              cell_out,
    output logic              pin_out,
    output logic              irq_flag
);

    ctrl_t ctrl_q;
    logic  polarity_q;
    logic  flag_clr;

    lcc_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .POLAR_ADDR(POLAR_ADDR),
        .FLAG_ADDR (FLAG_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cell_out (cell_out),
        .irq_flag (irq_flag),
        .ctrl     (ctrl_q),
        .polarity (polarity_q),
        .flag_clr (flag_clr),
        .bus_rdata(bus_rdata)
    );

    lcc_func func_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_q.en),
        .mode    (ctrl_q.mode),
        .polarity(polarity_q),
        .gate_in (gate_in),
        .cell_out(cell_out)
    );

    lcc_edge_irq edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cell_out(cell_out),
        .int_rise(ctrl_q.int_rise),
        .int_fall(ctrl_q.int_fall),
        .flag_clr(flag_clr),
        .irq_flag(irq_flag)
    );

    assign pin_out = ctrl_q.oe & cell_out;

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker
    import lcc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input ctrl_t      ctrl,
    input logic       pol,
    input logic       cell_out,
    input logic       irq_flag,
    input logic       flag_clr,
    input logic [3:0] gate_in
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_flag && ctrl == '0 && !pol));

    // R2
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !cell_out);

    // R12
    rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.int_rise && $rose(cell_out)) |=> irq_flag);

    // R12
    fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.int_fall && $fell(cell_out)) |=> irq_flag);

    // R13
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R13
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && !(ctrl.int_rise && $rose(cell_out))
                   && !(ctrl.int_fall && $fell(cell_out))) |=> !irq_flag);

    // R6
    seq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.mode inside {MODE_DFF_SR, MODE_DFF2_R, MODE_JK_R, MODE_LATCH_SR}
         && gate_in[2])
        |=> ((ctrl != $past(ctrl)) || (pol != $past(pol)) || (cell_out == pol)));

endmodule

bind logic_cell_core lcc_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_q),
    .pol     (polarity_q),
    .cell_out(cell_out),
    .irq_flag(irq_flag),
    .flag_clr(flag_clr),
    .gate_in (gate_in)
);

// File: tb/logic_cell_core_tb_top.sv
`timescale 1ns/1ps
module logic_cell_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] gate_in = '0;
    logic       cell_out, pin_out, irq_flag;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    logic_cell_core dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_in(gate_in),
        .cell_out(cell_out), .pin_out(pin_out), .irq_flag(irq_flag)
    );

    // bench model state, derived from the requirements
    logic [7:0] m_ctrl = '0;
    logic       m_pol = 0, m_q = 0, m_g1p = 0, m_outp = 0, m_flag = 0;

    function automatic logic m_raw(logic [2:0] md, logic [3:0] g, logic q);
        if (md == 3'd0) return (g[0] & g[1]) | (g[2] & g[3]);
        if (md == 3'd1) return (g[0] | g[1]) ^ (g[2] | g[3]);
        if (md == 3'd2) return g == 4'hF;
        return q;
    endfunction

    function automatic logic m_out(logic [7:0] c, logic p, logic [3:0] g, logic q);
        if (!c[7]) return 1'b0;
        return m_raw(c[2:0], g, q) ^ p;
    endfunction

    function automatic logic m_next(logic [7:0] c, logic [3:0] g, logic q, logic g1p);
        logic rise;
        rise = g[0] && !g1p;
        if (!c[7] || c[2:0] < 3'd3) return 1'b0;
        if (c[2:0] == 3'd3) return (g[2] | g[3]) ? 1'b0 : ((g[0] | g[1]) ? 1'b1 : q);
        if (g[2]) return 1'b0;
        case (c[2:0])
            3'd4: return g[3] ? 1'b1 : (rise ? g[1] : q);
            3'd5: return rise ? (g[1] ^ g[3]) : q;
            3'd6: begin
                if (!rise) return q;
                if (g[1] && g[3]) return !q;
                if (g[1]) return 1'b1;
                if (g[3]) return 1'b0;
                return q;
            end
            default: return g[3] ? 1'b1 : (g[0] ? g[1] : q);
        endcase
    endfunction

    function automatic string mode_tag(logic [7:0] c, logic p);
        string t;
        if (!c[7]) return "R2";
        case (c[2:0])
            3'd0, 3'd1, 3'd2: t = "R4";
            3'd3: t = "R5";
            3'd4: t = "R6";
            3'd5: t = "R7";
            3'd6: t = "R8";
            default: t = "R9";
        endcase
        if (p) t = {t, "/R10"};
        return t;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(logic we, logic [1:0] a, logic [7:0] wd, logic [3:0] g);
        logic o, rise, fall, set, clr;
        logic [7:0] rd;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; gate_in = g;
        #1;
        o = m_out(m_ctrl, m_pol, g, m_q);
        chk(mode_tag(m_ctrl, m_pol), {7'b0, cell_out}, {7'b0, o});
        chk("R3", {7'b0, pin_out}, {7'b0, o & m_ctrl[6]});
        chk("R12/R13", {7'b0, irq_flag}, {7'b0, m_flag});
        case (a)
            2'd0: rd = {m_ctrl[7:6], o, m_ctrl[4:0]};
            2'd1: rd = {7'b0, m_pol};
            2'd2: rd = {7'b0, m_flag};
            default: rd = 8'h00;
        endcase
        chk("R11", bus_rdata, rd);
        @(posedge clk);
        rise = o && !m_outp;
        fall = !o && m_outp;
        set = (rise && m_ctrl[4]) || (fall && m_ctrl[3]);
        clr = we && a == 2'd2 && !wd[0];
        m_flag = set || (m_flag && !clr);
        m_q = m_next(m_ctrl, g, m_q, m_g1p);
        m_g1p = g[0];
        m_outp = o;
        if (we && a == 2'd0) m_ctrl = wd & 8'hDF;
        if (we && a == 2'd1) m_pol = wd[0];
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] wd, logic [3:0] g);
        cyc(1'b1, a, wd, g);
    endtask

    task automatic idle(logic [3:0] g);
        cyc(1'b0, 2'd0, 8'h00, g);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R1: reset values through the bus and outputs
        for (int a = 0; a < 3; a++) begin
            bus_addr = 2'(a);
            #1;
            chk("R1", bus_rdata, 8'h00);
        end
        chk("R1", {5'b0, cell_out, pin_out, irq_flag}, 8'h00);
        rst_n = 1'b1;

        // R2: disabled cell ignores gates
        idle(4'hF); idle(4'h3);
        // R4: combinational modes over all gate patterns
        for (int m = 0; m < 3; m++) begin
            wr(2'd0, 8'h80 | 8'(m), 4'h0);
            for (int g = 0; g < 16; g++) idle(4'(g));
        end
        // R11/R3: bit 5 write ignored, output enable drives pin
        wr(2'd0, 8'hE0, 4'hF); idle(4'hF); idle(4'h0);
        wr(2'd0, 8'h80, 4'hF); idle(4'hF);
        // R5: SR latch, set, hold, reset, both
        wr(2'd0, 8'hC3, 4'h0);
        idle(4'h1); idle(4'h0); idle(4'h2); idle(4'h4); idle(4'h0);
        idle(4'h1); idle(4'h5); idle(4'h0); idle(4'h8);
        // R6: D flip-flop with set/reset
        wr(2'd0, 8'hC4, 4'h0);
        idle(4'h2); idle(4'h3); idle(4'h2); idle(4'h0); idle(4'h1);
        idle(4'h8); idle(4'h0); idle(4'hC); idle(4'h0); idle(4'h3); idle(4'h7);
        // R7: two-input D
        wr(2'd0, 8'h85, 4'h0);
        idle(4'h3); idle(4'h0); idle(4'h9); idle(4'h0); idle(4'hB); idle(4'h4);
        // R8: JK toggles, set, clear, hold
        wr(2'd0, 8'h86, 4'h0);
        for (int k = 0; k < 3; k++) begin idle(4'hB); idle(4'hA); idle(4'h0); end
        idle(4'h3); idle(4'h0); idle(4'h9); idle(4'h0); idle(4'h1); idle(4'h0);
        idle(4'h3); idle(4'h7);
        // R9: transparent latch
        wr(2'd0, 8'h87, 4'h0);
        idle(4'h3); idle(4'h1); idle(4'h0); idle(4'h2); idle(4'h8); idle(4'hC);
        // R10: polarity
        wr(2'd1, 8'h01, 4'h0);
        wr(2'd0, 8'h80, 4'h0); idle(4'h3); idle(4'h0);
        wr(2'd1, 8'h00, 4'h0);
        // R12/R13: edge flags, clears, write-one ignored, set beats clear
        wr(2'd0, 8'h90, 4'h0); idle(4'h3); idle(4'h0);
        cyc(1'b0, 2'd2, 8'h00, 4'h0);
        wr(2'd2, 8'h01, 4'h0); wr(2'd2, 8'h00, 4'h0);
        wr(2'd0, 8'h88, 4'h3); idle(4'h3); idle(4'h0); idle(4'h0);
        wr(2'd2, 8'h00, 4'h0);
        wr(2'd0, 8'h98, 4'h0); idle(4'h0); wr(2'd2, 8'h00, 4'h3);
        cyc(1'b0, 2'd2, 8'h00, 4'h3);
        wr(2'd2, 8'h00, 4'h0); cyc(1'b0, 2'd2, 8'h00, 4'h0);

        // constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            logic       we;
            logic [1:0] a;
            logic [7:0] wd;
            we = ($urandom % 10) == 0;
            a  = 2'($urandom % 4);
            wd = 8'($urandom);
            if (a == 2'd0 && ($urandom % 4) != 0) wd[7] = 1'b1;
            if (a == 2'd2 && we) wd[0] = ($urandom % 3) == 0;
            cyc(we, a, wd, 4'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule